// File: doc/BRIEF.md
# Frequency-Step Dwell Sequencer

This block owns the load-level value that selects one of four operating points, 0 being the fastest and 3 the slowest. When the base clock runs at 1 GHz or more, the top level must never be entered straight from level 2 or level 3. The supply needs time to settle first. The sequencer takes a requested level together with two flags. One says the target rate is at least 1 GHz. The other says the base rate is at least 1 GHz. From these it decides whether to apply the request at once or to step through level 1 first.

A dwell record tracks time spent at level 1. It is empty, running, or met. A running record counts tick strobes: the parameter `TICKS_PER_MS` sets ticks per millisecond and `DWELL_MS` sets the dwell length, so `TICKS_PER_MS*DWELL_MS` ticks make one full dwell. A level-0 request that finds the record met is applied directly. Otherwise the block writes level 1 and raises `busy_o` for a full dwell, then writes level 0. Requests that arrive while busy are dropped.

Levels are encoded as plain binary 0 to 3 on 2 bits. Every output is registered. An accepted request, or a dwell that completes, shows on the outputs after the clock edge on which it is sampled.

Top module: `lvl_step_seq`

## Requirements
- R1: After reset, `level_o` is 0, and `busy_o` and `dwell_met_o` are 0.
- R2: With `base_fast_i` low, an accepted request is written to `level_o` at the next edge and `busy_o` stays low. Moving to level 1 this way does not set `dwell_met_o`.
- R3: A request equal to the current `level_o` changes nothing.
- R4: With `base_fast_i` high, a request for level 1 made from level 0 sets `dwell_met_o` at the same edge that writes level 1.
- R5: With `base_fast_i` high, a request for level 1 made from level 2 or 3 writes level 1 and starts the record running. `dwell_met_o` rises after `TICKS_PER_MS*DWELL_MS` tick strobes have been counted at level 1.
- R6: With `base_fast_i` and `req_fast_i` high, a request for level 0 while the record is not met writes level 1 and raises `busy_o`. After a full dwell of ticks, `level_o` becomes 0 and `busy_o` falls on the same edge.
- R7: With `base_fast_i` and `req_fast_i` high, a request for level 0 while `dwell_met_o` is high writes level 0 at once, without busy.
- R8: A request for level 2 or 3, or for level 0 with `req_fast_i` low, is applied at once without busy. Any move to level 0, 2 or 3 clears the record, so `dwell_met_o` is 0 afterwards.
- R9: While `busy_o` is high, `level_o` stays at 1 and incoming requests are ignored.
- R10: A level-0 request that finds the record still running discards the partial progress and waits a full dwell.
- R11: Only cycles with `tick_i` high advance the dwell. Without ticks the record never becomes met and a busy wait never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_level_i | input | 2 | Requested level, 0 to 3 |
| req_fast_i | input | 1 | Target rate is at least 1 GHz |
| base_fast_i | input | 1 | Base rate is at least 1 GHz |
| tick_i | input | 1 | Time-base strobe, `TICKS_PER_MS` per millisecond |
| level_o | output | 2 | Current load level |
| busy_o | output | 1 | Dwell wait before level 0 in progress |
| dwell_met_o | output | 1 | Record says the level-1 dwell is satisfied |

## Verification
Each internal fault reaches the ports within a few cycles. A wrong record state shows up as `dwell_met_o` disagreeing with the reference within one edge. It also shows up on the next level-0 request, which then either skips the wait or takes a needless detour through level 1 with `busy_o` high. A tick counter that is off by one moves the falling edge of `busy_o`, and the rising edge of `dwell_met_o`, by one tick period. The bench compares all three outputs every cycle, so that shift is caught at the edge where it happens.

// File: rtl/lvl_step_pkg.sv
package lvl_step_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;

    // dwell record: nothing pending, counting at level 1, or satisfied
    typedef enum logic [1:0] {
        REC_NONE = 2'd0,
        REC_RUN  = 2'd1,
        REC_MET  = 2'd2
    } rec_e;
endpackage

// File: rtl/lvl_step_dwell.sv
module lvl_step_dwell #(
    parameter int TICKS_PER_MS = 1000,
    parameter int DWELL_MS     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int N_TICKS = TICKS_PER_MS * DWELL_MS;
    localparam int CW = (N_TICKS > 1) ? $clog2(N_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(N_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dw_t;

    dw_t d, q;

    always_comb begin
        done_o = run_i && tick_i && (q.cnt == LAST);
        d = q;
        if (restart_i || !run_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            d.cnt = done_o ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: the tick count never passes the dwell length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);

    // R11: the count moves only on a tick strobe
    a_r11_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i && run_i) |=> $stable(q.cnt));
endmodule

// File: rtl/lvl_step_ctrl.sv
module lvl_step_ctrl
    import lvl_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  lvl_t req_level_i,
    input  logic req_fast_i,
    input  logic base_fast_i,
    input  logic done_i,
    output lvl_t level_o,
    output logic busy_o,
    output rec_e rec_o,
    output logic restart_o
);
    typedef struct packed {
        lvl_t level;
        rec_e rec;
        logic busy;
    } st_t;

    st_t d, q;
    logic accept;

    always_comb begin
        d         = q;
        restart_o = 1'b0;
        accept    = req_valid_i && !q.busy && (req_level_i != q.level);

        // dwell completion: finish a pending step to level 0, or mark met
        if (q.rec == REC_RUN && done_i) begin
            if (q.busy) begin
                d.level = 2'd0;
                d.rec   = REC_NONE;
                d.busy  = 1'b0;
            end else begin
                d.rec = REC_MET;
            end
        end

        if (accept) begin
            if (!base_fast_i) begin
                d.level = req_level_i;
                if (req_level_i != 2'd1) d.rec = REC_NONE;
            end else begin
                case (req_level_i)
                    2'd1: begin
                        d.level = 2'd1;
                        if (q.level == 2'd0) begin
                            d.rec = REC_MET;
                        end else begin
                            d.rec     = REC_RUN;
                            restart_o = 1'b1;
                        end
                    end
                    2'd0: begin
                        if (!req_fast_i || d.rec == REC_MET) begin
                            d.level = 2'd0;
                            d.rec   = REC_NONE;
                        end else begin
                            d.level   = 2'd1;
                            d.rec     = REC_RUN;
                            d.busy    = 1'b1;
                            restart_o = 1'b1;
                        end
                    end
                    default: begin
                        d.level = req_level_i;
                        d.rec   = REC_NONE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{level: 2'd0, rec: REC_NONE, busy: 1'b0};
        else        q <= d;
    end

    assign level_o = q.level;
    assign busy_o  = q.busy;
    assign rec_o   = q.rec;

    // R9: a pending step to level 0 holds level 1
    a_r9_busy_at_l1: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.level == 2'd1));

    // R6: the wait always ends at level 0
    a_r6_busy_exit_l0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.level == 2'd0));

    // R6: no direct jump from level 2/3 to level 0 under fast target and base
    a_r6_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.level == 2'd0) && ($past(q.level) >= 2'd2))
            |-> !($past(base_fast_i) && $past(req_fast_i)));

    // R3: a request for the current level leaves it alone
    a_r3_same_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !q.busy && (req_level_i == q.level)) |=> $stable(q.level));

    // R8: the record is met only while sitting at level 1
    a_r8_met_at_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rec == REC_MET) |-> (q.level == 2'd1));
endmodule

// File: rtl/lvl_step_seq.sv
module lvl_step_seq
    import lvl_step_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000,
    parameter int DWELL_MS     = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic [1:0] req_level_i,
    input  logic       req_fast_i,
    input  logic       base_fast_i,
    input  logic       tick_i,
    output logic [1:0] level_o,
    output logic       busy_o,
    output logic       dwell_met_o
);
    rec_e rec;
    logic restart;
    logic done;

    lvl_step_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_level_i (req_level_i),
        .req_fast_i  (req_fast_i),
        .base_fast_i (base_fast_i),
        .done_i      (done),
        .level_o     (level_o),
        .busy_o      (busy_o),
        .rec_o       (rec),
        .restart_o   (restart)
    );

    lvl_step_dwell #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .DWELL_MS     (DWELL_MS)
    ) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (rec == REC_RUN),
        .tick_i    (tick_i),
        .done_o    (done)
    );

    assign dwell_met_o = (rec == REC_MET);
endmodule

// File: tb/lvl_step_seq_test.sv
module lvl_step_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int TPM   = 2;
    localparam int DMS   = 3;
    localparam int NTICK = TPM * DMS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_level = 2'd0;
    logic       req_fast = 1'b0;
    logic       base_fast = 1'b0;
    logic       tick;
    logic [1:0] level_o;
    logic       busy_o;
    logic       dwell_met_o;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  tdiv = 0;
    bit  tick_en = 1'b1;
    string phase = "R1";

    // reference model state: rec 0 none, 1 running, 2 met
    int m_lvl = 0, m_rec = 0, m_cnt = 0, m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_step_seq #(.TICKS_PER_MS(TPM), .DWELL_MS(DMS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_level_i(req_level),
        .req_fast_i(req_fast), .base_fast_i(base_fast), .tick_i(tick),
        .level_o(level_o), .busy_o(busy_o), .dwell_met_o(dwell_met_o)
    );

    always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    assign tick = tick_en && (tdiv == 2);

    always @(posedge clk) begin
        int nl, nr, nc, nb, rq;
        bit dn;
        if (!rst_n) begin
            m_lvl = 0; m_rec = 0; m_cnt = 0; m_busy = 0;
        end else begin
            nl = m_lvl; nr = m_rec; nb = m_busy;
            dn = (m_rec == 1) && tick && (m_cnt == NTICK - 1);
            if (m_rec != 1) nc = 0;
            else if (tick)  nc = dn ? 0 : m_cnt + 1;
            else            nc = m_cnt;
            if (dn) begin
                if (m_busy != 0) begin nl = 0; nr = 0; nb = 0; end
                else nr = 2;
            end
            rq = int'(req_level);
            if (req_valid && m_busy == 0 && rq != m_lvl) begin
                if (!base_fast) begin
                    nl = rq;
                    if (rq != 1) nr = 0;
                end else if (rq == 1) begin
                    nl = 1;
                    if (m_lvl == 0) nr = 2;
                    else begin nr = 1; nc = 0; end
                end else if (rq == 0) begin
                    if (!req_fast || nr == 2) begin nl = 0; nr = 0; end
                    else begin nl = 1; nr = 1; nb = 1; nc = 0; end
                end else begin
                    nl = rq; nr = 0;
                end
            end
            m_lvl = nl; m_rec = nr; m_cnt = nc; m_busy = nb;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk({phase, " model level"}, int'(level_o), m_lvl);
            chk({phase, " model busy"}, int'(busy_o), m_busy);
            chk({phase, " model met"}, int'(dwell_met_o), (m_rec == 2) ? 1 : 0);
        end
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(int lvl, bit fast);
        @(negedge clk);
        req_valid = 1'b1; req_level = 2'(lvl); req_fast = fast;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 level", int'(level_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 met", int'(dwell_met_o), 0);

        phase = "R2"; base_fast = 1'b0;
        send(3, 1); chk("R2 level 3", int'(level_o), 3); chk("R2 busy", int'(busy_o), 0);
        send(1, 1); chk("R2 level 1", int'(level_o), 1); chk("R2 no met", int'(dwell_met_o), 0);
        send(0, 1); chk("R2 level 0", int'(level_o), 0); chk("R2 busy", int'(busy_o), 0);

        phase = "R3"; base_fast = 1'b1;
        send(0, 1); chk("R3 level", int'(level_o), 0); chk("R3 busy", int'(busy_o), 0);

        phase = "R4";
        send(1, 1); chk("R4 level", int'(level_o), 1); chk("R4 met", int'(dwell_met_o), 1);
        phase = "R7";
        send(0, 1); chk("R7 level", int'(level_o), 0); chk("R7 busy", int'(busy_o), 0);

        phase = "R5";
        send(2, 1); send(1, 1);
        chk("R5 level", int'(level_o), 1); chk("R5 met early", int'(dwell_met_o), 0);
        idle(10); chk("R5 met mid", int'(dwell_met_o), 0);
        idle(20); chk("R5 met after dwell", int'(dwell_met_o), 1);

        phase = "R8";
        send(3, 1); chk("R8 met cleared", int'(dwell_met_o), 0);
        send(1, 1); send(0, 0);
        chk("R8 slow target level", int'(level_o), 0); chk("R8 busy", int'(busy_o), 0);
        send(3, 1);

        phase = "R6";
        send(0, 1); chk("R6 step level", int'(level_o), 1); chk("R6 busy", int'(busy_o), 1);
        phase = "R9";
        send(2, 1); chk("R9 ignored level", int'(level_o), 1); chk("R9 busy", int'(busy_o), 1);
        phase = "R6";
        idle(30); chk("R6 final level", int'(level_o), 0); chk("R6 busy low", int'(busy_o), 0);
        chk("R6 met cleared", int'(dwell_met_o), 0);

        phase = "R10";
        send(2, 1); send(1, 1); idle(6);
        send(0, 1); chk("R10 busy", int'(busy_o), 1);
        idle(12); chk("R10 still busy", int'(busy_o), 1); chk("R10 level", int'(level_o), 1);
        idle(20); chk("R10 done level", int'(level_o), 0);

        phase = "R11";
        tick_en = 1'b0;
        send(2, 1); send(1, 1); idle(60);
        chk("R11 no ticks no met", int'(dwell_met_o), 0);
        tick_en = 1'b1;
        idle(30); chk("R11 met with ticks", int'(dwell_met_o), 1);

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule